// File: doc/BRIEF.md
# Host/Engine Readiness and Aliveness Handshake

This block keeps the interface state shared by a host and an embedded engine. It has two small register ports, one per side. Both ports decode the same four registers, so each side reads the same bits.

The readiness handshake works like this. Each side sets or clears only its own ready bit. The system counts as ready only while both bits are set. Either side can issue a self-clearing clear command, which drops both bits at once.

The aliveness handshake works like this. The host posts a request and the engine acknowledges it within a bounded wait. If no acknowledgement arrives in time, the request is withdrawn and a sticky timeout flag is raised. A second timer watches how long the host waits for the engine to become ready.

The block sends one-cycle cause pulses to an interrupt aggregator on each side. Timeouts are set in clock ticks: a unit tick count is multiplied by a per-timeout unit count. The wait timeout defaults to 1 unit and the ready timeout to 5 units.

Top module: `ipc_sync_handshake`

## Requirements
- R1: After reset, all register reads on both ports are 0, and `sys_rdy_o`, both cause outputs and `tmo_o` are 0.
- R2: Register map, by 2-bit address:
  - Address 0 reads {0, engine-ready, host-ready}, with host-ready at bit 0 and engine-ready at bit 1.
  - A host write to address 0 sets host-ready to data bit 0 and ignores data bit 1.
  - An engine write to address 0 sets engine-ready to data bit 1 and ignores data bit 0.
  - Each change is visible from the next clock edge.
- R3: `sys_rdy_o` is 1 exactly when both ready bits are 1, and it changes in the same cycle as the bits.
- R4: A write to address 0 from either port with data bit 2 set clears both ready bits at the next edge. This clear wins over the other data bits of the same write. Bit 2 always reads 0.
- R5: Readiness change pulses:
  - `eng_cause_o[0]` pulses for one cycle when the host-ready bit changes value.
  - `host_cause_o[0]` pulses for one cycle when the engine-ready bit changes value.
  - Each pulse is high in the first cycle the new value is readable.
- R6: Aliveness request (address 1, bit 0 reads the pending request):
  - A host write of bit 0 = 1 while no request is pending sets the pending bit, clears the response bit, and pulses `eng_cause_o[1]`.
  - While a request is pending, a new host request is ignored. It gives no pulse and does not restart the wait.
  - Engine writes to address 1 are ignored.
- R7: Aliveness acknowledge (address 2, bit 0 reads the response):
  - An engine write of bit 0 = 1 while a request is pending clears the pending bit, sets the response bit, and pulses `host_cause_o[1]`.
  - When no request is pending, the same write is ignored.
- R8: A host write of bit 0 = 1 to address 2 clears the response bit. If an acknowledgement is accepted in the same cycle, the set wins.
- R9: Let AW be ALIVE_WAIT_UNITS × UNIT_TICKS. If no acknowledgement is accepted at any of the AW edges after a request is accepted, then at the AW-th edge the pending bit clears and `tmo_o[0]` sets. An acknowledgement sampled at that AW-th edge is still accepted and raises no timeout.
- R10: Let RW be READY_WAIT_UNITS × UNIT_TICKS. If host-ready is 1 and engine-ready is 0 for RW consecutive edges, `tmo_o[1]` sets at the RW-th edge. Any edge without that condition restarts the count.
- R11: Both `tmo_o` bits are sticky until reset, and they read at address 3 as {0, ready-timeout, aliveness-timeout}.
- R12: The host and engine read ports return identical data whenever they present the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_we_i | input | 1 | Host write strobe |
| h_addr_i | input | 2 | Host register address |
| h_wdata_i | input | 3 | Host write data |
| h_rdata_o | output | 3 | Host read data (combinational) |
| e_we_i | input | 1 | Engine write strobe |
| e_addr_i | input | 2 | Engine register address |
| e_wdata_i | input | 3 | Engine write data |
| e_rdata_o | output | 3 | Engine read data (combinational) |
| sys_rdy_o | output | 1 | Both sides ready |
| host_cause_o | output | 2 | Pulses to host: [0] engine-ready changed, [1] acknowledge accepted |
| eng_cause_o | output | 2 | Pulses to engine: [0] host-ready changed, [1] request accepted |
| tmo_o | output | 2 | Sticky timeouts: [0] aliveness wait, [1] ready wait |

## Verification
The assertions check the following on every cycle:
- a clear command leaves both ready bits low;
- a host write never moves the engine bit;
- an accepted acknowledgement leaves response set and request cleared;
- a pending request persists until acknowledge or expiry;
- timeout flags never fall, and the wait counters stay in range;
- the two read views agree.

Only the bench scenarios can show the exact cycles involved. These are the expiry edge of each wait, the win of an acknowledgement sampled on that edge, the ignored re-request not restarting the wait, and the cause pulses matching every ready-bit transition. The bench shows these by sweeping every write value over every starting readiness state from both ports.

// File: rtl/ipc_sync_pkg.sv
package ipc_sync_pkg;
  typedef enum logic [1:0] {
    REG_READY = 2'd0,
    REG_AREQ  = 2'd1,
    REG_ARSP  = 2'd2,
    REG_ERR   = 2'd3
  } hs_reg_e;

  localparam int unsigned BIT_HOST  = 0;
  localparam int unsigned BIT_ENG   = 1;
  localparam int unsigned BIT_CLR   = 2;
  localparam int unsigned BIT_ALIVE = 0;
  localparam int unsigned TMO_ALIVE = 0;
  localparam int unsigned TMO_READY = 1;
  localparam int unsigned DW        = 3;
  localparam int unsigned AW        = 2;
  localparam int unsigned NVIEW     = 2;
endpackage

// File: rtl/ipc_wait_timer.sv
module ipc_wait_timer #(
  parameter int unsigned LIMIT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + CW'(1);
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0); // R10
endmodule

// File: rtl/ipc_ready_reg.sv
module ipc_ready_reg #(
  parameter int unsigned WAIT_TICKS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic h_we_i,
  input  logic h_set_i,
  input  logic h_clr_i,
  input  logic e_we_i,
  input  logic e_set_i,
  input  logic e_clr_i,
  output logic host_rdy_o,
  output logic eng_rdy_o,
  output logic host_chg_o,
  output logic eng_chg_o,
  output logic wait_tmo_o
);
  logic host_q, eng_q, host_d, eng_d, clr;
  logic host_chg_q, eng_chg_q, tmo_q, expire;

  assign clr = (h_we_i && h_clr_i) || (e_we_i && e_clr_i);

  always_comb begin
    host_d = host_q;
    eng_d  = eng_q;
    if (clr) begin
      host_d = 1'b0;
      eng_d  = 1'b0;
    end else begin
      if (h_we_i) host_d = h_set_i;
      if (e_we_i) eng_d  = e_set_i;
    end
  end

  ipc_wait_timer #(.LIMIT(WAIT_TICKS)) i_rdy_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (host_q && !eng_q),
    .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_q     <= 1'b0;
      eng_q      <= 1'b0;
      host_chg_q <= 1'b0;
      eng_chg_q  <= 1'b0;
      tmo_q      <= 1'b0;
    end else begin
      host_q     <= host_d;
      eng_q      <= eng_d;
      host_chg_q <= host_d ^ host_q;
      eng_chg_q  <= eng_d ^ eng_q;
      tmo_q      <= tmo_q | expire;
    end
  end

  assign host_rdy_o = host_q;
  assign eng_rdy_o  = eng_q;
  assign host_chg_o = host_chg_q;
  assign eng_chg_o  = eng_chg_q;
  assign wait_tmo_o = tmo_q;

  AST_CLR_DROPS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((h_we_i && h_clr_i) || (e_we_i && e_clr_i)) |=> (!host_q && !eng_q)); // R4
  AST_HOST_KEEPS_ENG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_we_i && !h_clr_i && !e_we_i) |=> $stable(eng_q)); // R2
  AST_ENG_KEEPS_HOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_we_i && !e_clr_i && !h_we_i) |=> $stable(host_q)); // R2
  AST_HOST_CHG_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_q != $past(host_q)) |-> host_chg_q); // R5
  AST_RDY_TMO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_q |=> tmo_q); // R11
endmodule

// File: rtl/ipc_alive_ctrl.sv
module ipc_alive_ctrl #(
  parameter int unsigned WAIT_TICKS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ack_i,
  input  logic rsp_clr_i,
  output logic pend_o,
  output logic resp_o,
  output logic req_cause_o,
  output logic ack_cause_o,
  output logic tmo_o
);
  logic pend_q, resp_q, req_c_q, ack_c_q, tmo_q;
  logic req_ok, ack_ok, expire;

  assign req_ok = req_i && !pend_q;
  assign ack_ok = ack_i && pend_q;

  ipc_wait_timer #(.LIMIT(WAIT_TICKS)) i_alive_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (pend_q),
    .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      resp_q  <= 1'b0;
      req_c_q <= 1'b0;
      ack_c_q <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      if (ack_ok || expire) pend_q <= 1'b0;
      else if (req_ok)      pend_q <= 1'b1;
      if (ack_ok)                 resp_q <= 1'b1;
      else if (req_ok || rsp_clr_i) resp_q <= 1'b0;
      req_c_q <= req_ok;
      ack_c_q <= ack_ok;
      tmo_q   <= tmo_q | (expire && !ack_ok);
    end
  end

  assign pend_o      = pend_q;
  assign resp_o      = resp_q;
  assign req_cause_o = req_c_q;
  assign ack_cause_o = ack_c_q;
  assign tmo_o       = tmo_q;

  AST_ACK_SETS_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pend_q) |=> (resp_q && !pend_q && ack_c_q)); // R7
  AST_IDLE_ACK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q) |=> !ack_c_q); // R7
  AST_PEND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ack_i && !expire) |=> (pend_q && !req_c_q)); // R6
  AST_ALIVE_TMO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_q |=> tmo_q); // R11
endmodule

// File: rtl/ipc_sync_handshake.sv
module ipc_sync_handshake
  import ipc_sync_pkg::*;
#(
  parameter int unsigned UNIT_TICKS       = 1000,
  parameter int unsigned ALIVE_WAIT_UNITS = 1,
  parameter int unsigned READY_WAIT_UNITS = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       h_we_i,
  input  logic [1:0] h_addr_i,
  input  logic [2:0] h_wdata_i,
  output logic [2:0] h_rdata_o,
  input  logic       e_we_i,
  input  logic [1:0] e_addr_i,
  input  logic [2:0] e_wdata_i,
  output logic [2:0] e_rdata_o,
  output logic       sys_rdy_o,
  output logic [1:0] host_cause_o,
  output logic [1:0] eng_cause_o,
  output logic [1:0] tmo_o
);
  localparam int unsigned ALIVE_TICKS = ALIVE_WAIT_UNITS * UNIT_TICKS;
  localparam int unsigned READY_TICKS = READY_WAIT_UNITS * UNIT_TICKS;

  logic host_rdy, eng_rdy, host_chg, eng_chg, rdy_tmo;
  logic pend, resp, req_cause, ack_cause, alive_tmo;
  logic h_wr_rdy, e_wr_rdy, h_wr_req, h_wr_rsp, e_wr_rsp;
  logic [NVIEW-1:0][AW-1:0] view_addr;
  logic [NVIEW-1:0][DW-1:0] view_data;
  logic unused_wbits;

  assign h_wr_rdy = h_we_i && (h_addr_i == REG_READY);
  assign e_wr_rdy = e_we_i && (e_addr_i == REG_READY);
  assign h_wr_req = h_we_i && (h_addr_i == REG_AREQ) && h_wdata_i[BIT_ALIVE];
  assign h_wr_rsp = h_we_i && (h_addr_i == REG_ARSP) && h_wdata_i[BIT_ALIVE];
  assign e_wr_rsp = e_we_i && (e_addr_i == REG_ARSP) && e_wdata_i[BIT_ALIVE];
  assign unused_wbits = h_wdata_i[BIT_ENG];

  ipc_ready_reg #(.WAIT_TICKS(READY_TICKS)) i_ready (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .h_we_i    (h_wr_rdy),
    .h_set_i   (h_wdata_i[BIT_HOST]),
    .h_clr_i   (h_wdata_i[BIT_CLR]),
    .e_we_i    (e_wr_rdy),
    .e_set_i   (e_wdata_i[BIT_ENG]),
    .e_clr_i   (e_wdata_i[BIT_CLR]),
    .host_rdy_o(host_rdy),
    .eng_rdy_o (eng_rdy),
    .host_chg_o(host_chg),
    .eng_chg_o (eng_chg),
    .wait_tmo_o(rdy_tmo)
  );

  ipc_alive_ctrl #(.WAIT_TICKS(ALIVE_TICKS)) i_alive (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (h_wr_req),
    .ack_i      (e_wr_rsp),
    .rsp_clr_i  (h_wr_rsp),
    .pend_o     (pend),
    .resp_o     (resp),
    .req_cause_o(req_cause),
    .ack_cause_o(ack_cause),
    .tmo_o      (alive_tmo)
  );

  assign view_addr[0] = h_addr_i;
  assign view_addr[1] = e_addr_i;

  for (genvar v = 0; v < NVIEW; v++) begin : g_view
    always_comb begin
      unique case (hs_reg_e'(view_addr[v]))
        REG_READY: view_data[v] = {1'b0, eng_rdy, host_rdy};
        REG_AREQ:  view_data[v] = {2'b00, pend};
        REG_ARSP:  view_data[v] = {2'b00, resp};
        REG_ERR:   view_data[v] = {1'b0, rdy_tmo, alive_tmo};
        default:   view_data[v] = '0;
      endcase
    end
  end

  assign h_rdata_o    = view_data[0];
  assign e_rdata_o    = view_data[1];
  assign sys_rdy_o    = host_rdy && eng_rdy;
  assign host_cause_o = {ack_cause, eng_chg};
  assign eng_cause_o  = {req_cause, host_chg};
  assign tmo_o        = {rdy_tmo, alive_tmo};

  AST_VIEWS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_addr_i == e_addr_i) |-> (h_rdata_o == e_rdata_o)); // R12
  AST_SYS_RDY_FALLS_ON_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_wr_rdy && e_wdata_i[BIT_CLR]) |=> !sys_rdy_o); // R3
endmodule

// File: tb/test_ipc_sync_handshake.sv
`timescale 1ns/1ps
module test_ipc_sync_handshake;
  localparam int unsigned UNIT = 3;
  localparam int unsigned AWT  = 1 * UNIT;
  localparam int unsigned RWT  = 5 * UNIT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_we = 1'b0, e_we = 1'b0;
  logic [1:0] h_addr = '0, e_addr = '0;
  logic [2:0] h_wdata = '0, e_wdata = '0;
  logic [2:0] h_rdata, e_rdata;
  logic sys_rdy;
  logic [1:0] host_cause, eng_cause, tmo;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ipc_sync_handshake #(.UNIT_TICKS(UNIT), .ALIVE_WAIT_UNITS(1), .READY_WAIT_UNITS(5)) i_ipc_sync_handshake (
    .clk_i(clk), .rst_ni(rst_n),
    .h_we_i(h_we), .h_addr_i(h_addr), .h_wdata_i(h_wdata), .h_rdata_o(h_rdata),
    .e_we_i(e_we), .e_addr_i(e_addr), .e_wdata_i(e_wdata), .e_rdata_o(e_rdata),
    .sys_rdy_o(sys_rdy), .host_cause_o(host_cause), .eng_cause_o(eng_cause), .tmo_o(tmo)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // read a register from both views (R12) at the current time
  task automatic rd(input string tag, input logic [1:0] a, input int exp);
    h_addr = a;
    e_addr = a;
    #0.5;
    chk({tag, " host view"}, h_rdata, exp);
    chk({tag, " engine view R12"}, e_rdata, exp);
  endtask

  // caller sits at a negedge; the write is sampled at the next posedge
  task automatic wr(input bit eng, input logic [1:0] a, input logic [2:0] d);
    if (eng) begin e_we = 1'b1; e_addr = a; e_wdata = d; end
    else     begin h_we = 1'b1; h_addr = a; h_wdata = d; end
    @(negedge clk);
    h_we = 1'b0;
    e_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    h_we = 1'b0; e_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    for (int a = 0; a < 4; a++) rd("R1 reset read", 2'(a), 0);
    chk("R1 sys_rdy", sys_rdy, 0);
    chk("R1 host_cause", host_cause, 0);
    chk("R1 eng_cause", eng_cause, 0);
    chk("R1 tmo", tmo, 0);

    // readiness sweep: start state x side x data (R2 R3 R4 R5)
    for (int hs = 0; hs < 2; hs++)
      for (int es = 0; es < 2; es++)
        for (int side = 0; side < 2; side++)
          for (int d = 0; d < 8; d++) begin
            int nh, ne;
            wr(1'b0, 2'd0, 3'b100);
            wr(1'b0, 2'd0, 3'(hs));
            wr(1'b1, 2'd0, 3'(es << 1));
            wr(side != 0, 2'd0, 3'(d));
            if (d[2]) begin nh = 0; ne = 0; end
            else if (side == 0) begin nh = d & 1; ne = es; end
            else begin nh = hs; ne = (d >> 1) & 1; end
            chk("R5 eng_cause readiness", eng_cause[0], int'(nh != hs));
            chk("R5 host_cause readiness", host_cause[0], int'(ne != es));
            chk("R3 sys_rdy", sys_rdy, nh & ne);
            rd(d[2] ? "R4 clear readback" : "R2 readiness readback", 2'd0, nh + 2 * ne);
          end

    // R6 engine writes to request register ignored
    wr(1'b1, 2'd1, 3'b111);
    chk("R6 engine request no cause", eng_cause[1], 0);
    rd("R6 engine request ignored", 2'd1, 0);

    // aliveness
    do_reset();
    wr(1'b1, 2'd2, 3'b001);
    chk("R7 idle ack no cause", host_cause[1], 0);
    rd("R7 idle ack ignored", 2'd2, 0);
    wr(1'b0, 2'd1, 3'b001);
    chk("R6 request cause", eng_cause[1], 1);
    rd("R6 request pending", 2'd1, 1);
    wr(1'b1, 2'd2, 3'b001);
    chk("R7 ack cause", host_cause[1], 1);
    rd("R7 ack clears pending", 2'd1, 0);
    rd("R7 ack sets response", 2'd2, 1);
    wr(1'b0, 2'd2, 3'b001);
    rd("R8 host clears response", 2'd2, 0);
    wr(1'b0, 2'd1, 3'b001);
    wr(1'b1, 2'd2, 3'b001);
    rd("R7 response set again", 2'd2, 1);
    wr(1'b0, 2'd1, 3'b001);                     // accepted at edge k
    rd("R6 new request clears response", 2'd2, 0);
    wr(1'b0, 2'd1, 3'b001);                     // k+1, ignored
    chk("R6 repeat request no cause", eng_cause[1], 0);
    @(negedge clk);                             // after k+2
    rd("R9 pending before expiry", 2'd1, 1);
    chk("R9 no timeout yet", tmo[0], 0);
    @(negedge clk);                             // after k+3 = AWT
    rd("R9 pending withdrawn", 2'd1, 0);
    chk("R9 alive timeout", tmo[0], 1);
    rd("R11 error register", 2'd3, 1);
    wr(1'b1, 2'd2, 3'b001);
    rd("R7 late ack ignored", 2'd2, 0);
    wr(1'b0, 2'd1, 3'b001);
    wr(1'b1, 2'd2, 3'b001);
    chk("R11 alive timeout sticky", tmo[0], 1);

    // ack on the expiry edge wins
    do_reset();
    wr(1'b0, 2'd1, 3'b001);                     // edge k
    repeat (AWT - 1) @(negedge clk);
    wr(1'b1, 2'd2, 3'b001);                     // sampled at k+AWT
    rd("R9 boundary ack accepted", 2'd2, 1);
    chk("R9 boundary no timeout", tmo[0], 0);

    // ready wait
    do_reset();
    wr(1'b0, 2'd0, 3'b001);                     // edge k
    repeat (RWT - 1) @(negedge clk);
    chk("R10 ready wait not yet", tmo[1], 0);
    @(negedge clk);
    chk("R10 ready wait expired", tmo[1], 1);
    rd("R11 error register ready", 2'd3, 2);
    wr(1'b0, 2'd0, 3'b100);
    chk("R11 ready timeout sticky", tmo[1], 1);

    do_reset();
    wr(1'b0, 2'd0, 3'b001);
    repeat (RWT - 5) @(negedge clk);
    wr(1'b1, 2'd0, 3'b010);
    repeat (RWT + 2) @(negedge clk);
    chk("R10 engine ready in time", tmo[1], 0);
    chk("R3 system ready", sys_rdy, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule